// File: doc/BRIEF.md
# Multi-Channel Timebase Timer

This block is a register-mapped timer bank. It has four event channels that count down (channel 0 to channel 3) and one timestamp counter that counts up and never stops. A single control word sets each event channel's run bit, its repeat-or-single behaviour and its tick source. The same word also selects the tick source of the timestamp. A built-in prescaler turns the system clock into strobes of 1 µs, 10 µs, 100 µs and 1 ms. The parameter `CLK_PER_US` gives the number of system clocks in one microsecond.

Each event channel is a three-state machine:

- `CH_HALT`: the channel is stopped and its count is frozen.
- `CH_COUNT`: the channel decrements on each selected tick.
- `CH_SPENT`: a single-shot channel has fired and is waiting.

The channel takes these transitions:

- *start*: from `CH_HALT` to `CH_COUNT` when the run bit becomes 1.
- *stop*: from `CH_COUNT` or `CH_SPENT` to `CH_HALT` when the run bit becomes 0.
- *expire-once*: from `CH_COUNT` to `CH_SPENT` on a tick at count zero in single mode.
- *expire-repeat*: from `CH_COUNT` back to `CH_COUNT` with a reload, on a tick at count zero in repeat mode.
- *rearm*: from `CH_SPENT` to `CH_COUNT` when software writes the count register.

When a channel expires, it pulses its interrupt line for one clock. Software can read the timestamp at any time to measure elapsed time.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset, the control word reads 0, all four channel counts read 0, and no interrupt is raised.
- R2: The control word is at byte offset 0x00 and has these fields:
  - run bits for channels 3..0 at bits 19..16;
  - repeat bits for channels 3..0 at bits 15..12 (1 = repeat, 0 = single);
  - timestamp source at bits 10:8;
  - channel source fields at bits 7:6 (channel 3), 5:4 (channel 2), 3:2 (channel 1) and 1:0 (channel 0).

  All other bits read back as 0.
- R3: The count registers of channels 0..3 are at offsets 0x04, 0x08, 0x0C and 0x10. A write stores the low `CNT_W` bits as both the live count and the reload value. A read returns the live count, zero-extended.
- R4: A 2-bit channel source code picks the tick: 0 = 1 µs, 1 = 10 µs, 2 = 100 µs, 3 = 1 ms. One microsecond is `CLK_PER_US` clocks.
- R5: In repeat mode with programmed value N, the channel fires every N+1 ticks and reloads N each time.
- R6: In single mode, the channel fires once after N+1 ticks. It then holds a count of 0 and fires no more until its count register is written again.
- R7: Each interrupt is a pulse exactly one clock wide. It is raised only while the channel's run bit is set.
- R8: Clearing a run bit freezes that channel's count from the write cycle on, with no interrupt. Setting the bit again resumes decrementing from the frozen value.
- R9: The timestamp source code selects how the timestamp advances:
  - 0: by one every clock;
  - 1, 2, 3 and 4: by one per 1 µs, 10 µs, 100 µs and 1 ms tick;
  - 5 to 7: it holds.
- R10: The timestamp is `STAMP_W` bits wide. It wraps from all ones to zero. It reads at offset 0x14, zero-extended.
- R11: These accesses are ignored:
  - writes to offset 0x14;
  - accesses to offsets 0x18 and above;
  - accesses whose two low address bits are not 00.

  Reads of unmapped or unaligned offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the register accessed |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_irq | output | 4 | One-clock expiry pulse for each event channel |

## Verification
The bound checker checks these properties on every cycle:

- An interrupt never appears without its run bit and is never wider than one clock.
- A stopped channel's count cannot move unless its count register is written.
- The timestamp moves by at most one per clock, and by exactly one per clock in raw-clock mode.

The directed scenarios show what a property cannot:

- the exact repeat periods of each prescaler tap;
- the single fire and rearm of single mode;
- resumption from the frozen value after a stop;
- the tick counts of every timestamp source;
- wrap-around, and the register layout with its ignored writes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int N_EVT     = 4;
    localparam int RUN_LSB   = 16;
    localparam int RPT_LSB   = 12;
    localparam int TSEL_LSB  = 8;
    localparam int TSEL_W    = 3;
    localparam int CSEL_W    = 2;
    localparam int N_TAPS    = 4;
    localparam logic [31:0] CTRL_MASK = 32'h000F_F7FF;

    typedef enum logic [1:0] {
        CH_HALT  = 2'd0,
        CH_COUNT = 2'd1,
        CH_SPENT = 2'd2
    } ch_state_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int CLK_PER_US = 50,
    parameter int DECADES    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [DECADES:0] strobe
);
    localparam int UW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

    logic [UW-1:0] us_cnt;
    logic          us_wrap;

    assign us_wrap   = (us_cnt == UW'(CLK_PER_US - 1));
    assign strobe[0] = us_wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       us_cnt <= '0;
        else if (us_wrap) us_cnt <= '0;
        else              us_cnt <= us_cnt + 1'b1;
    end

    // Each decade stage divides the previous strobe by ten.
    for (genvar k = 0; k < DECADES; k++) begin : g_dec
        logic [3:0] dcnt;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         dcnt <= '0;
            else if (strobe[k]) dcnt <= (dcnt == 4'd9) ? 4'd0 : dcnt + 4'd1;
        end
        assign strobe[k+1] = strobe[k] && (dcnt == 4'd9);
    end
endmodule

// File: rtl/tmr_event_chan.sv
module tmr_event_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             repeat_mode,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             fire
);
    ch_state_t        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, rld_q;
    logic             step, at_zero;

    assign at_zero = (cnt_q == '0);
    assign step    = (st_q == CH_COUNT) && run && tick && !load;

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_HALT:  if (run) st_d = CH_COUNT;                    // start
            CH_COUNT: if (!run) st_d = CH_HALT;                    // stop
                      else if (step && at_zero && !repeat_mode)
                          st_d = CH_SPENT;                         // expire-once
            CH_SPENT: if (!run) st_d = CH_HALT;                    // stop
                      else if (load) st_d = CH_COUNT;              // rearm
            default:  st_d = CH_HALT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_HALT;
        else        st_q <= st_d;
    end

    // Count and reload datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rld_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
            rld_q <= load_val;
        end else if (step) begin
            if (!at_zero)         cnt_q <= cnt_q - 1'b1;
            else if (repeat_mode) cnt_q <= rld_q;                  // expire-repeat
        end
    end

    // Outputs
    always_comb begin
        fire  = step && at_zero;
        count = cnt_q;
    end
endmodule

// File: rtl/tmr_stamp.sv
module tmr_stamp
    import tmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TSEL_W-1:0] sel,
    input  logic [N_TAPS-1:0] strobe,
    output logic [W-1:0]      value
);
    logic adv;

    always_comb begin
        unique case (sel)
            3'd0:    adv = 1'b1;
            3'd1:    adv = strobe[0];
            3'd2:    adv = strobe[1];
            3'd3:    adv = strobe[2];
            3'd4:    adv = strobe[3];
            default: adv = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   value <= '0;
        else if (adv) value <= value + 1'b1;
    end
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
    import tmr_pkg::*;
#(
    parameter int CLK_PER_US = 50,
    parameter int CNT_W      = 16,
    parameter int STAMP_W    = 32,
    parameter int ADDR_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [N_EVT-1:0]  evt_irq
);
    localparam int IDX_W    = ADDR_W - 2;
    localparam int STAMP_IX = N_EVT + 1;

    logic [IDX_W-1:0]       idx;
    logic                   aligned;
    logic [31:0]            ctrl_q;
    logic                   ctrl_wr;
    logic [N_TAPS-1:0]      strobe;
    logic [STAMP_W-1:0]     stamp_q;
    logic [N_EVT*CNT_W-1:0] cnt_vec;

    assign idx     = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign ctrl_wr = bus_wr && aligned && (idx == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= bus_wdata & CTRL_MASK;
    end

    tmr_prescaler #(.CLK_PER_US(CLK_PER_US), .DECADES(N_TAPS - 1)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe)
    );

    for (genvar i = 0; i < N_EVT; i++) begin : g_ch
        logic             run_now, load, tick;
        logic [CNT_W-1:0] count;

        // A write to the run bit takes effect in the write cycle itself.
        assign run_now = ctrl_wr ? bus_wdata[RUN_LSB+i] : ctrl_q[RUN_LSB+i];
        assign load    = bus_wr && aligned && (idx == IDX_W'(i + 1));
        assign tick    = strobe[ctrl_q[CSEL_W*i +: CSEL_W]];

        tmr_event_chan #(.CNT_W(CNT_W)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .run         (run_now),
            .repeat_mode (ctrl_q[RPT_LSB+i]),
            .tick        (tick),
            .load        (load),
            .load_val    (bus_wdata[CNT_W-1:0]),
            .count       (count),
            .fire        (evt_irq[i])
        );
        assign cnt_vec[i*CNT_W +: CNT_W] = count;
    end

    tmr_stamp #(.W(STAMP_W)) u_stamp (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (ctrl_q[TSEL_LSB +: TSEL_W]),
        .strobe (strobe),
        .value  (stamp_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (idx == '0) bus_rdata = ctrl_q;
            if (idx == IDX_W'(STAMP_IX)) bus_rdata = 32'(stamp_q);
            for (int i = 0; i < N_EVT; i++)
                if (idx == IDX_W'(i + 1)) bus_rdata = 32'(cnt_vec[i*CNT_W +: CNT_W]);
        end
    end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int CLK_PER_US = 50,
    parameter int CNT_W      = 16,
    parameter int STAMP_W    = 32,
    parameter int ADDR_W     = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_EVT-1:0]       irq,
    input logic [N_EVT-1:0]       run_bits,
    input logic [TSEL_W-1:0]      tsel,
    input logic [STAMP_W-1:0]     stamp,
    input logic [N_EVT*CNT_W-1:0] cnts,
    input logic                   bus_wr,
    input logic [ADDR_W-1:0]      bus_addr
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    for (genvar i = 0; i < N_EVT; i++) begin : g_chk
        logic hit;
        assign hit = bus_wr && (bus_addr[1:0] == 2'b00) &&
                     (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(i + 1));

        p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> run_bits[i]);

        if (CLK_PER_US > 1) begin : g_narrow
            p_irq_narrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
                irq[i] |=> !irq[i]);
        end

        p_hold_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_bits[i] && !hit) |=> $stable(cnts[i*CNT_W +: CNT_W]));
    end

    p_stamp_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (stamp == $past(stamp) || stamp == STAMP_W'($past(stamp) + 1'b1)));

    p_raw_stamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(tsel) == '0) |-> stamp == STAMP_W'($past(stamp) + 1'b1));
endmodule

bind tick_timer_bank tmr_checker #(
    .CLK_PER_US (CLK_PER_US),
    .CNT_W      (CNT_W),
    .STAMP_W    (STAMP_W),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (evt_irq),
    .run_bits (ctrl_q[19:16]),
    .tsel     (ctrl_q[10:8]),
    .stamp    (stamp_q),
    .cnts     (cnt_vec),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr)
);

// File: tb/tick_timer_bank_bench.sv
module tick_timer_bank_bench;
    localparam int CPU = 4;
    localparam int SW  = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  evt_irq;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    bit done = 0;
    int n_irq[4], last_at[4], gap[4];
    bit seen[4], wide[4], prev_irq[4];

    always #10 clk = ~clk;

    tick_timer_bank #(.CLK_PER_US(CPU), .STAMP_W(SW)) u_tick_timer_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_irq(evt_irq)
    );

    always @(posedge clk) cyc <= cyc + 1;

    initial for (int i = 0; i < 4; i++) begin
        n_irq[i] = 0; last_at[i] = 0; gap[i] = 0;
        seen[i] = 0; wide[i] = 0; prev_irq[i] = 0;
    end

    always @(negedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (evt_irq[i]) begin
                n_irq[i]++;
                if (seen[i]) gap[i] = cyc - last_at[i];
                last_at[i] = cyc;
                seen[i] = 1;
                if (prev_irq[i]) wide[i] = 1;
            end
            prev_irq[i] = evt_irq[i];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(5'h00, v); chk("R1 ctrl", v, 0);
        for (int a = 1; a <= 4; a++) begin
            rd(5'(a * 4), v); chk("R1 count", v, 0);
        end
        chk("R1 irq", 32'(n_irq[0] + n_irq[1] + n_irq[2] + n_irq[3]), 0);
    endtask

    task automatic t_ctrl_layout;
        logic [31:0] v;
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, v); chk("R2 mask", v, 32'h000F_F7FF);
        wr(5'h00, 32'h0);
        rd(5'h00, v); chk("R2 clear", v, 0);
    endtask

    task automatic t_count_regs;
        logic [31:0] v;
        wr(5'h04, 32'h1234_0ABC); wr(5'h08, 32'h11);
        wr(5'h0C, 32'h22);        wr(5'h10, 32'h33);
        rd(5'h04, v); chk("R3 ch0", v, 32'h0ABC);
        rd(5'h08, v); chk("R3 ch1", v, 32'h11);
        rd(5'h0C, v); chk("R3 ch2", v, 32'h22);
        rd(5'h10, v); chk("R3 ch3", v, 32'h33);
    endtask

    task automatic t_periodic;
        int n0;
        wr(5'h04, 32'd2);
        wr(5'h00, 32'h0001_1000);
        idle(30);
        @(negedge clk); n0 = n_irq[0];
        repeat (120) @(negedge clk);
        chk("R5 count in 120 clocks", 32'(n_irq[0] - n0), 10);
        chk("R5 gap", 32'(gap[0]), 12);
        chk("R7 width", 32'(wide[0]), 0);
        wr(5'h00, 32'h0);
    endtask

    task automatic t_prescale;
        wr(5'h08, 32'd1); wr(5'h0C, 32'd0); wr(5'h10, 32'd0);
        wr(5'h00, 32'h000E_E0E4);
        idle(9000);
        chk("R4 10us gap", 32'(gap[1]), 80);
        chk("R4 100us gap", 32'(gap[2]), 400);
        chk("R4 1ms gap", 32'(gap[3]), 4000);
        chk("R7 width taps", 32'(wide[1] | wide[2] | wide[3]), 0);
        wr(5'h00, 32'h0);
    endtask

    task automatic t_oneshot;
        int n0;
        logic [31:0] v;
        n0 = n_irq[0];
        wr(5'h04, 32'd3);
        wr(5'h00, 32'h0001_0000);
        idle(200);
        chk("R6 one fire", 32'(n_irq[0] - n0), 1);
        rd(5'h04, v); chk("R6 holds zero", v, 0);
        idle(200);
        chk("R6 no refire", 32'(n_irq[0] - n0), 1);
        wr(5'h04, 32'd3);
        idle(200);
        chk("R6 rearm", 32'(n_irq[0] - n0), 2);
        wr(5'h00, 32'h0);
    endtask

    task automatic t_freeze;
        int n0;
        logic [31:0] c1, c2, c3;
        wr(5'h04, 32'd1000);
        wr(5'h00, 32'h0001_1000);
        idle(200);
        wr(5'h00, 32'h0000_1000);
        n0 = n_irq[0];
        rd(5'h04, c1);
        chk("R8 counted", 32'(c1 < 1000), 1);
        idle(100);
        rd(5'h04, c2); chk("R8 frozen", c2, c1);
        chk("R8 no irq", 32'(n_irq[0] - n0), 0);
        wr(5'h00, 32'h0001_1000);
        idle(40);
        rd(5'h04, c3); chk("R8 resume", c3, c1 - 10);
        wr(5'h00, 32'h0);
    endtask

    task automatic stamp_win(input logic [2:0] code, input int len, input int exp);
        logic [31:0] v0, v1;
        wr(5'h00, {21'b0, code, 8'b0});
        idle(10);
        rd(5'h14, v0);
        idle(len);
        rd(5'h14, v1);
        chk($sformatf("R9 stamp code %0d", code), (v1 - v0) & 32'hFFF, 32'(exp));
    endtask

    task automatic t_stamp;
        stamp_win(3'd0, 37, 37);
        stamp_win(3'd1, 40, 10);
        stamp_win(3'd2, 400, 10);
        stamp_win(3'd3, 800, 2);
        stamp_win(3'd4, 8000, 2);
        stamp_win(3'd5, 50, 0);
    endtask

    task automatic t_wrap;
        logic [31:0] v, w;
        int d;
        wr(5'h00, 32'h0);
        rd(5'h14, v);
        d = 4096 - int'(v) + 5;
        idle(d);
        rd(5'h14, w);
        chk("R10 wrap", w, 32'd5);
    endtask

    task automatic t_ignored;
        logic [31:0] v, w;
        wr(5'h00, 32'h0000_0500);
        rd(5'h14, v);
        wr(5'h14, 32'h0000_0ABC);
        rd(5'h14, w); chk("R11 stamp write", w, v);
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h18, w); chk("R11 unmapped read", w, 0);
        wr(5'h01, 32'hFFFF_FFFF);
        rd(5'h01, w); chk("R11 unaligned read", w, 0);
        rd(5'h00, w); chk("R11 ctrl kept", w, 32'h0000_0500);
    endtask

    initial begin
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        idle(2);
        t_reset;
        t_ctrl_layout;
        t_count_regs;
        t_periodic;
        t_prescale;
        t_oneshot;
        t_freeze;
        t_stamp;
        t_wrap;
        t_ignored;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule